// File: doc/BRIEF.md
# Power-up Protocol Selector with Answer-to-Reset Transmitter

This block sits at the pad side of a dual-protocol secure memory. After each power-on reset it watches the reset pad, the card clock pad and the I/O line, and picks one of two interfaces for the rest of the power cycle: a synchronous two-wire bus or the asynchronous half-duplex smart card character protocol. The reset pad has an internal pull-up model. When the host leaves the pad undriven, the pad reads high, and the bus mode is the natural outcome.

When the asynchronous interface is chosen, the block sends an eight-character answer-to-reset on the open-drain I/O line. The character contents come from an input port. A bit lasts one elementary time unit, which is a fixed number of card clock periods. The output is a drive-low enable: a zero bit pulls the line down, and a one bit releases it to the external pull-up. A later fall and rise of the reset pad, while the asynchronous interface stays selected, aborts the transmission and restarts it from the first character. In bus mode the line is never driven. Command handling after this point is left to other blocks.

Top module: `card_proto_sel`

## Requirements
- R1: While and right after power-on reset, the I/O drive-low enable is 0, the mode-locked flag is 0 and the asynchronous flag is 0.
- R2: An undriven reset pad reads as high, so card clock pulses with the pad undriven never select the asynchronous interface.
- R3: The asynchronous interface is locked when the reset pad rises after it has been seen low for at least LOW_MIN (default 16) card clock rising edges. A rise after fewer low edges locks nothing.
- R4: The two-wire interface is locked by a START-like event, which is the I/O line falling while the card clock and the reset pad are both high. The event counts once at least PRE_PULSES (default 5) card clock rising edges have been seen since power-on reset, including the edge that began the current high phase.
- R5: A START-like event that comes before the fifth card clock rising edge is ignored and leaves the block unlocked.
- R6: Once locked, the mode flags do not change until the next power-on reset. Later reset pad cycles and START-like events do not switch the mode.
- R7: The answer-to-reset has 8 characters. Character n is atr_bytes[8n+7:8n], and character 0 is sent first. Each character has 12 bit slots: a start bit at 0, eight data bits with the LSB first, an even parity bit (the XOR of the data bits), and two guard slots at 1. After the last guard slot the line stays released.
- R8: Each bit slot lasts ETU_CLKS card clock rising edges (default 372), and the start bit of character 0 begins as soon as the asynchronous lock is taken.
- R9: In two-wire mode, and while unlocked, the drive-low enable stays 0.
- R10: In asynchronous mode, a low reset pad releases the line within 4 clock cycles. The next rise of the pad restarts the answer-to-reset from character 0.
- R11: The drive-low enable is 1 only while a 0 bit is being sent, and a 1 bit leaves the line released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| por | input | 1 | Power-on reset, synchronous, active high |
| rstpad_drv | input | 1 | 1 when the host drives the reset pad |
| rstpad_lvl | input | 1 | Level driven on the reset pad when rstpad_drv is 1 |
| cardclk_in | input | 1 | Card clock / serial clock pad level |
| io_in | input | 1 | Observed level of the I/O line |
| atr_bytes | input | 8*ATR_CHARS | Answer-to-reset characters, character 0 in the low byte |
| io_drive_low | output | 1 | 1 pulls the open-drain I/O line low |
| proto_locked | output | 1 | 1 once a protocol has been chosen in this power cycle |
| proto_async | output | 1 | 1 when the asynchronous interface is the chosen one |

## Verification
The hardest situations to reach are the two boundaries in mode selection. One is a reset-low period of exactly LOW_MIN card clock edges against one edge fewer. The other is a START-like event on the fourth card clock rise against the fifth. The stimulus drives both pads and the card clock from the bench, so it places every card clock edge and every pad transition itself. Each boundary is reached with an exact edge count, and all three inputs pass through the same synchronizer depth, so the edges line up the same way in the design. The warm restart partway through the answer-to-reset is reached by letting two characters complete, pulling the reset pad low, and then decoding the first character again.

// File: rtl/proto_sel_pkg.sv
package proto_sel_pkg;

  typedef enum logic [1:0] {
    MODE_OPEN  = 2'd0,
    MODE_WIRE  = 2'd1,
    MODE_CARD  = 2'd2
  } proto_mode_t;

  localparam int unsigned SLOTS_PER_CHAR = 12;

  // Level of one slot of a character frame: 0 = start, 1..8 = data LSB first,
  // 9 = even parity, 10..11 = guard.
  function automatic logic slot_level(input logic [3:0] slot, input logic [7:0] d);
    logic lvl;
    if (slot == 4'd0)
      lvl = 1'b0;
    else if (slot <= 4'd8)
      lvl = d[slot - 4'd1];
    else if (slot == 4'd9)
      lvl = ^d;
    else
      lvl = 1'b1;
    return lvl;
  endfunction

endpackage

// File: rtl/psel_sync.sv
module psel_sync #(
  parameter int unsigned WIDTH   = 3,
  parameter int unsigned STAGES  = 2,
  parameter logic [WIDTH-1:0] INIT = '0
) (
  input  logic             clk,
  input  logic             por,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (por)
        chain <= {STAGES{INIT[b]}};
      else
        chain <= {chain[STAGES-2:0], din[b]};
    end
    assign dout[b] = chain[STAGES-1];
  end

endmodule

// File: rtl/psel_decide.sv
module psel_decide
  import proto_sel_pkg::*;
#(
  parameter int unsigned LOW_MIN    = 16,
  parameter int unsigned PRE_PULSES = 5
) (
  input  logic        clk,
  input  logic        por,
  input  logic        ck_rise,
  input  logic        ck_s,
  input  logic        rst_s,
  input  logic        io_s,
  output proto_mode_t mode,
  output logic        kick
);

  localparam int unsigned LOW_W = $clog2(LOW_MIN + 1);
  localparam int unsigned PUL_W = $clog2(PRE_PULSES + 1);

  logic [LOW_W-1:0] low_cnt;
  logic [PUL_W-1:0] pul_cnt;
  logic             rst_prev;
  logic             io_prev;
  logic             rst_rise;
  logic             start_evt;
  logic             low_ok;
  logic             pulses_ok;

  assign rst_rise  = rst_s & ~rst_prev;
  assign start_evt = io_prev & ~io_s & ck_s & rst_s;
  assign low_ok    = (low_cnt >= LOW_W'(LOW_MIN));
  assign pulses_ok = (pul_cnt >= PUL_W'(PRE_PULSES));
  assign kick      = rst_rise & ((mode == MODE_CARD) | ((mode == MODE_OPEN) & low_ok));

  always_ff @(posedge clk) begin
    if (por) begin
      low_cnt  <= '0;
      pul_cnt  <= '0;
      rst_prev <= 1'b1;
      io_prev  <= 1'b1;
      mode     <= MODE_OPEN;
    end else begin
      rst_prev <= rst_s;
      io_prev  <= io_s;
      if (ck_rise && !pulses_ok)
        pul_cnt <= pul_cnt + 1'b1;
      if (rst_s)
        low_cnt <= '0;
      else if (ck_rise && !low_ok)
        low_cnt <= low_cnt + 1'b1;
      if (mode == MODE_OPEN) begin
        if (rst_rise && low_ok)
          mode <= MODE_CARD;
        else if (start_evt && pulses_ok)
          mode <= MODE_WIRE;
      end
    end
  end

endmodule

// File: rtl/psel_atr_tx.sv
module psel_atr_tx
  import proto_sel_pkg::*;
#(
  parameter int unsigned ETU_CLKS  = 372,
  parameter int unsigned ATR_CHARS = 8
) (
  input  logic                   clk,
  input  logic                   por,
  input  logic                   kick,
  input  logic                   hold,
  input  logic                   ck_rise,
  input  logic [8*ATR_CHARS-1:0] atr_bytes,
  output logic                   tx_active,
  output logic                   tx_level
);

  localparam int unsigned ETU_W = (ETU_CLKS > 1) ? $clog2(ETU_CLKS) : 1;
  localparam int unsigned CH_W  = (ATR_CHARS > 1) ? $clog2(ATR_CHARS) : 1;

  logic [ETU_W-1:0] etu_cnt;
  logic [3:0]       slot;
  logic [CH_W-1:0]  chr;
  logic [7:0]       cur_byte;

  assign cur_byte = atr_bytes[chr*8 +: 8];
  assign tx_level = slot_level(slot, cur_byte);

  always_ff @(posedge clk) begin
    if (por || hold) begin
      tx_active <= 1'b0;
      etu_cnt   <= '0;
      slot      <= '0;
      chr       <= '0;
    end else if (kick) begin
      tx_active <= 1'b1;
      etu_cnt   <= '0;
      slot      <= '0;
      chr       <= '0;
    end else if (tx_active && ck_rise) begin
      if (etu_cnt == ETU_W'(ETU_CLKS - 1)) begin
        etu_cnt <= '0;
        if (slot == 4'(SLOTS_PER_CHAR - 1)) begin
          slot <= '0;
          if (chr == CH_W'(ATR_CHARS - 1))
            tx_active <= 1'b0;
          else
            chr <= chr + 1'b1;
        end else begin
          slot <= slot + 1'b1;
        end
      end else begin
        etu_cnt <= etu_cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/card_proto_sel.sv
module card_proto_sel
  import proto_sel_pkg::*;
#(
  parameter int unsigned ETU_CLKS    = 372,
  parameter int unsigned ATR_CHARS   = 8,
  parameter int unsigned LOW_MIN     = 16,
  parameter int unsigned PRE_PULSES  = 5,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   por,
  input  logic                   rstpad_drv,
  input  logic                   rstpad_lvl,
  input  logic                   cardclk_in,
  input  logic                   io_in,
  input  logic [8*ATR_CHARS-1:0] atr_bytes,
  output logic                   io_drive_low,
  output logic                   proto_locked,
  output logic                   proto_async
);

  logic        rst_pad;
  logic [2:0]  pads_s;
  logic        ck_s;
  logic        rst_s;
  logic        io_s;
  logic        ck_prev;
  logic        ck_rise;
  proto_mode_t mode;
  logic        kick;
  logic        tx_active;
  logic        tx_level;

  // pull-up model: an undriven pad reads high
  assign rst_pad = rstpad_drv ? rstpad_lvl : 1'b1;

  psel_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .INIT(3'b110)) u_sync (
    .clk  (clk),
    .por  (por),
    .din  ({io_in, rst_pad, cardclk_in}),
    .dout (pads_s)
  );

  assign ck_s  = pads_s[0];
  assign rst_s = pads_s[1];
  assign io_s  = pads_s[2];

  always_ff @(posedge clk) begin
    if (por) ck_prev <= 1'b0;
    else     ck_prev <= ck_s;
  end
  assign ck_rise = ck_s & ~ck_prev;

  psel_decide #(.LOW_MIN(LOW_MIN), .PRE_PULSES(PRE_PULSES)) u_decide (
    .clk     (clk),
    .por     (por),
    .ck_rise (ck_rise),
    .ck_s    (ck_s),
    .rst_s   (rst_s),
    .io_s    (io_s),
    .mode    (mode),
    .kick    (kick)
  );

  psel_atr_tx #(.ETU_CLKS(ETU_CLKS), .ATR_CHARS(ATR_CHARS)) u_tx (
    .clk       (clk),
    .por       (por),
    .kick      (kick),
    .hold      (~rst_s),
    .ck_rise   (ck_rise),
    .atr_bytes (atr_bytes),
    .tx_active (tx_active),
    .tx_level  (tx_level)
  );

  always_ff @(posedge clk) begin
    if (por) begin
      io_drive_low <= 1'b0;
      proto_locked <= 1'b0;
      proto_async  <= 1'b0;
    end else begin
      io_drive_low <= (mode == MODE_CARD) & rst_s & tx_active & ~tx_level;
      proto_locked <= (mode != MODE_OPEN);
      proto_async  <= (mode == MODE_CARD);
    end
  end

endmodule

// File: rtl/psel_checker.sv
module psel_checker (
  input logic clk,
  input logic por,
  input logic rst_s,
  input logic io_drive_low,
  input logic proto_locked,
  input logic proto_async
);

  // R1: outputs quiet after power-on reset
  a_r1_por_quiet: assert property (@(posedge clk)
    por |=> (!io_drive_low && !proto_locked && !proto_async));

  // R6: mode sticky once locked
  a_r6_mode_sticky: assert property (@(posedge clk) disable iff (por)
    proto_locked |=> (proto_locked && $stable(proto_async)));

  // R3 / R4: asynchronous flag only with a lock
  a_r3_async_needs_lock: assert property (@(posedge clk) disable iff (por)
    !proto_locked |-> !proto_async);

  // R9 / R11: the line is pulled only in asynchronous mode
  a_r9_drive_only_async: assert property (@(posedge clk) disable iff (por)
    io_drive_low |-> (proto_locked && proto_async));

  // R10: low reset pad releases the line
  a_r10_reset_releases: assert property (@(posedge clk) disable iff (por)
    (proto_async && !rst_s) |=> !io_drive_low);

endmodule

bind card_proto_sel psel_checker u_psel_checker (
  .clk          (clk),
  .por          (por),
  .rst_s        (rst_s),
  .io_drive_low (io_drive_low),
  .proto_locked (proto_locked),
  .proto_async  (proto_async)
);

// File: tb/tb_card_proto_sel.sv
module tb_card_proto_sel;

  localparam int ETU_T  = 8;
  localparam int CHARS  = 8;
  localparam int NVEC   = 3;
  // {expect_async, low_pulses[7:0], atr[63:0]}
  localparam logic [72:0] VEC [NVEC] = '{
    {1'b1, 8'd20, 64'h0F_A5_3C_81_00_FF_96_3B},
    {1'b1, 8'd16, 64'h12_34_56_78_9A_BC_DE_F0},
    {1'b0, 8'd15, 64'hDE_AD_BE_EF_01_23_45_67}
  };

  logic clk = 1'b0;
  logic por = 1'b1;
  logic rstpad_drv = 1'b0;
  logic rstpad_lvl = 1'b1;
  logic cardclk_in = 1'b0;
  logic io_in = 1'b1;
  logic [63:0] atr_bytes = '0;
  logic io_drive_low, proto_locked, proto_async;

  int total = 0;
  int bad = 0;
  logic quiet_watch = 1'b0;
  logic quiet_hit = 1'b0;

  always #10 clk = ~clk;

  card_proto_sel #(.ETU_CLKS(ETU_T), .ATR_CHARS(CHARS)) dut (
    .clk(clk), .por(por), .rstpad_drv(rstpad_drv), .rstpad_lvl(rstpad_lvl),
    .cardclk_in(cardclk_in), .io_in(io_in), .atr_bytes(atr_bytes),
    .io_drive_low(io_drive_low), .proto_locked(proto_locked), .proto_async(proto_async)
  );

  always @(negedge clk) if (quiet_watch && io_drive_low) quiet_hit = 1'b1;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic ck_cycle();
    cardclk_in = 1'b1; tick(2);
    cardclk_in = 1'b0; tick(2);
  endtask

  task automatic do_por();
    por = 1'b1; rstpad_drv = 1'b0; rstpad_lvl = 1'b1;
    io_in = 1'b1; cardclk_in = 1'b0;
    tick(4);
    por = 1'b0;
    tick(2);
  endtask

  task automatic start_evt();
    cardclk_in = 1'b1; tick(4);
    io_in = 1'b0; tick(4);
    io_in = 1'b1; tick(4);
    cardclk_in = 1'b0; tick(4);
  endtask

  task automatic async_entry(input int pulses);
    rstpad_drv = 1'b1; rstpad_lvl = 1'b0; tick(4);
    repeat (pulses) ck_cycle();
    tick(4);
    rstpad_drv = 1'b0; rstpad_lvl = 1'b1;
    tick(1);
  endtask

  task automatic decode_atr(input logic [63:0] exp, input int nchars);
    int waited;
    waited = 0;
    while (!io_drive_low && waited < 20) begin tick(1); waited++; end
    check("R8 start bit begins at lock", {63'd0, io_drive_low}, 64'd1);
    repeat (ETU_T / 2) ck_cycle();
    for (int ch = 0; ch < nchars; ch++) begin
      logic [11:0] fr;
      for (int s = 0; s < 12; s++) begin
        fr[s] = ~io_drive_low;
        repeat (ETU_T) ck_cycle();
      end
      check("R7 character byte", {56'd0, fr[8:1]}, {56'd0, exp[ch*8 +: 8]});
      check("R7 R11 start/parity/guard", {60'd0, fr[0], fr[9], fr[10], fr[11]},
            {60'd0, 1'b0, ^exp[ch*8 +: 8], 1'b1, 1'b1});
    end
  endtask

  initial begin
    tick(3);
    // R1: reset state
    check("R1 reset state", {61'd0, io_drive_low, proto_locked, proto_async}, 64'd0);
    do_por();
    check("R1 after por", {61'd0, io_drive_low, proto_locked, proto_async}, 64'd0);

    // table of ATR entry vectors
    for (int v = 0; v < NVEC; v++) begin
      logic expa;
      expa = VEC[v][72];
      do_por();
      atr_bytes = VEC[v][63:0];
      async_entry(int'(VEC[v][71:64]));
      tick(5);
      check("R3 lock vs low count", {62'd0, proto_locked, proto_async}, {62'd0, expa, expa});
      if (expa) begin
        decode_atr(VEC[v][63:0], CHARS);
        tick(4);
        check("R7 line released after last char", {63'd0, io_drive_low}, 64'd0);
        repeat (2 * ETU_T) ck_cycle();
        check("R7 no further characters", {63'd0, io_drive_low}, 64'd0);
      end else begin
        check("R9 no drive while unlocked", {63'd0, io_drive_low}, 64'd0);
        start_evt();
        check("R4 START after short low locks wire mode", {62'd0, proto_locked, proto_async}, 64'b10);
      end
    end

    // R2: undriven pad never selects async
    do_por();
    quiet_watch = 1'b1; quiet_hit = 1'b0;
    repeat (20) ck_cycle();
    tick(6);
    check("R2 pull-up keeps block unlocked", {62'd0, proto_locked, proto_async}, 64'd0);

    // R5 / R4 boundary: 4th rise ignored, 5th accepted
    do_por();
    repeat (3) ck_cycle();
    start_evt();
    check("R5 START on 4th edge ignored", {62'd0, proto_locked, proto_async}, 64'd0);
    start_evt();
    check("R4 START on 5th edge locks wire", {62'd0, proto_locked, proto_async}, 64'b10);

    // R6 / R9: wire mode survives a reset pad cycle, no ATR
    async_entry(20);
    tick(6);
    repeat (4 * ETU_T) ck_cycle();
    check("R6 wire mode sticky", {62'd0, proto_locked, proto_async}, 64'b10);
    check("R9 no ATR in wire mode", {63'd0, quiet_hit}, 64'd0);
    quiet_watch = 1'b0;

    // R10: warm restart mid ATR
    do_por();
    atr_bytes = 64'h55_44_33_22_11_C3_5A_A7;
    async_entry(18);
    decode_atr(atr_bytes, 2);
    rstpad_drv = 1'b1; rstpad_lvl = 1'b0;
    tick(4);
    check("R10 low pad releases line", {63'd0, io_drive_low}, 64'd0);
    repeat (3) ck_cycle();
    check("R10 line stays released", {63'd0, io_drive_low}, 64'd0);
    rstpad_drv = 1'b0; rstpad_lvl = 1'b1;
    tick(1);
    decode_atr(atr_bytes, 1);

    // R6: START in async mode does not switch
    start_evt();
    check("R6 async sticky against START", {62'd0, proto_locked, proto_async}, 64'b11);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule